// File: doc/BRIEF.md
# SDRAM burst column address generator

This block turns one column access request into the full list of column addresses for a memory burst, one address per clock. A request carries a 9-bit starting column, a burst length code, a wrap ordering, a read/write flag and a single-write enable. The block captures these on the request cycle. It then steps through the burst and marks the final address with a last flag.

A burst that is still running can be cut short in two ways. A terminate pulse stops it, as a burst-stop or precharge command would. A fresh request replaces it, since a new random column may be opened on any cycle. Fixed bursts of 1, 2, 4 or 8 wrap inside an aligned group of that size, in either sequential or interleaved order. A full-page burst walks all 512 columns in sequential order and keeps going until it is stopped. When the single-write enable is set, every write request is reduced to one beat, and reads keep their programmed length.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is applied, and on the first cycle after it, valid_o and last_o are low.
- R2: When start_i is high at a clock edge, the outputs after that edge show beat 0: valid_o=1 and col_o equal to col_i. This holds even if a burst is already running, which is abandoned and replaced by the new one.
- R3: blen_i selects the burst length. 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8 and 7 gives full page. The reserved codes 4, 5 and 6 give 1 beat. A fixed burst keeps valid_o high for exactly its length in cycles, and valid_o is low on the cycle after the last beat.
- R4: With wrap_i=0 and a fixed length BL, beat k has the start column's bits above log2(BL) unchanged, and its low log2(BL) bits equal (start low bits + k) mod BL.
- R5: With wrap_i=1 and a fixed length BL, beat k equals the start column with its low log2(BL) bits XORed with k.
- R6: last_o is high on beat BL-1 of a fixed-length burst and low on every other beat. last_o is never high while valid_o is low.
- R7: In a full-page burst, wrap_i is ignored and beat k equals (start + k) mod 512. last_o stays low, and the burst runs until term_i or start_i.
- R8: term_i high at an edge, with start_i low and a burst running, makes valid_o low after that edge. start_i in the same cycle wins over term_i. term_i while idle has no effect.
- R9: With wr_i=1 and bsw_i=1, the burst is 1 beat whatever blen_i is. With wr_i=0, or with bsw_i=0, blen_i applies unchanged.
- R10: col_i, blen_i, wrap_i, wr_i and bsw_i are used only in the cycle where start_i is high. Changing them during a burst does not alter its addresses or its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a new burst from col_i |
| col_i | input | 9 | Starting column |
| blen_i | input | 3 | Burst length code (0:1, 1:2, 2:4, 3:8, 7:full page, others:1) |
| wrap_i | input | 1 | 0 sequential, 1 interleaved |
| wr_i | input | 1 | 1 for a write request |
| bsw_i | input | 1 | Single-write enable: writes use one beat |
| term_i | input | 1 | End the running burst |
| col_o | output | 9 | Column address of the current beat |
| valid_o | output | 1 | col_o holds a burst beat |
| last_o | output | 1 | Current beat is the final one of a fixed burst |

## Verification
The hardest case to reach from the ports is a full-page burst that crosses from column 511 back to column 0. The stimulus gets there by starting a full-page burst at column 508 with interleave selected and holding it for 520 beats. The other hard cases are collisions: a new request landing in the middle of a burst, and a request and a terminate pulse arriving on the same edge. Directed sequences place these on exact beats. During every table burst the request inputs are scrambled, which shows that they are sampled only when a request is taken.

// File: rtl/bcg_pkg.sv
// Shared encodings for the burst column generator.
// Assumes: length codes 4..6 are reserved and treated as single beat.
package bcg_pkg;
    typedef enum logic [2:0] {
        BL_1    = 3'd0,
        BL_2    = 3'd1,
        BL_4    = 3'd2,
        BL_8    = 3'd3,
        BL_PAGE = 3'd7
    } blen_code_e;

    typedef enum logic {
        WRAP_SEQ = 1'b0,
        WRAP_ILV = 1'b1
    } wrap_e;
endpackage

// File: rtl/bcg_len_decode.sv
// Turns a length code plus the write and single-write flags into a wrap
// mask (BL-1) and a full-page flag.
// Assumes: COL_W >= 3 so that an 8-beat mask fits.
module bcg_len_decode #(
    parameter int COL_W = 9
) (
    input  logic [2:0]       code_i,
    input  logic             wr_i,
    input  logic             bsw_i,
    output logic [COL_W-1:0] mask_o,
    output logic             page_o
);
    import bcg_pkg::*;

    // Length selection; single-write forces a one-beat write.
    always_comb begin
        mask_o = '0;
        page_o = 1'b0;
        if (!(wr_i && bsw_i)) begin
            case (code_i)
                BL_2:    mask_o = COL_W'(1);
                BL_4:    mask_o = COL_W'(3);
                BL_8:    mask_o = COL_W'(7);
                BL_PAGE: begin
                    mask_o = '1;
                    page_o = 1'b1;
                end
                default: mask_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/bcg_seq_ctrl.sv
// Burst state: captures the request on start, counts beats, and ends the
// burst on the last beat or on terminate. A new start always takes over.
// Assumes: a full-page burst counts modulo 2**COL_W and never ends by itself.
module bcg_seq_ctrl #(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             term_i,
    input  logic [COL_W-1:0] col_i,
    input  logic             wrap_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             page_i,
    output logic             active_o,
    output logic [COL_W-1:0] cnt_o,
    output logic [COL_W-1:0] base_o,
    output logic [COL_W-1:0] mask_o,
    output logic             ilv_o,
    output logic             last_o
);
    import bcg_pkg::*;

    logic page_q;

    // Final beat of a fixed-length burst.
    assign last_o = active_o && !page_q && (cnt_o == mask_o);

    // Request capture and beat counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            cnt_o    <= '0;
            base_o   <= '0;
            mask_o   <= '0;
            ilv_o    <= 1'b0;
            page_q   <= 1'b0;
        end else if (start_i) begin
            active_o <= 1'b1;
            cnt_o    <= '0;
            base_o   <= col_i;
            mask_o   <= mask_i;
            ilv_o    <= (wrap_i == WRAP_ILV) && !page_i;
            page_q   <= page_i;
        end else if (active_o) begin
            if (term_i || last_o) begin
                active_o <= 1'b0;
            end else begin
                cnt_o <= cnt_o + COL_W'(1);
            end
        end
    end

    // R2: a start loads beat 0 from the requested column
    a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (active_o && cnt_o == '0 && base_o == $past(col_i)));

    // R8: terminate without start ends the burst
    a_r8_term_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && term_i && !start_i) |=> !active_o);

    // R6: nothing follows the last beat
    a_r6_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !active_o);

    // R7: full page keeps stepping until stopped
    a_r7_page_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && page_q && !term_i && !start_i)
            |=> (active_o && cnt_o == $past(cnt_o) + COL_W'(1)));

    // R10: captured request fields do not move during a burst
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !start_i) |=> ($stable(base_o) && $stable(mask_o) && $stable(ilv_o)));
endmodule

// File: rtl/bcg_addr_map.sv
// Forms the column of the current beat from the captured start column and
// the beat count: bits under the mask follow the wrap rule, the rest stay.
// Assumes: mask is a run of ones from bit 0 (BL-1).
module bcg_addr_map #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] cnt_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] sum;
    logic [COL_W-1:0] flip;

    // Sequential and interleaved candidates; carries only move upward.
    assign sum  = base_i + cnt_i;
    assign flip = base_i ^ cnt_i;

    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        // Per-bit selection between wrapped and fixed column bits.
        assign col_o[b] = mask_i[b] ? (ilv_i ? flip[b] : sum[b]) : base_i[b];
    end
endmodule

// File: rtl/burst_col_gen.sv
// Top of the burst column generator: decodes the length, runs the burst
// state and forms one column address per clock.
// Assumes: outputs appear the cycle after the start request edge.
module burst_col_gen #(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] col_i,
    input  logic [2:0]       blen_i,
    input  logic             wrap_i,
    input  logic             wr_i,
    input  logic             bsw_i,
    input  logic             term_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o
);
    logic [COL_W-1:0] dec_mask;
    logic             dec_page;
    logic [COL_W-1:0] cnt;
    logic [COL_W-1:0] base;
    logic [COL_W-1:0] mask_q;
    logic             ilv;

    bcg_len_decode #(.COL_W(COL_W)) len_i (
        .code_i (blen_i),
        .wr_i   (wr_i),
        .bsw_i  (bsw_i),
        .mask_o (dec_mask),
        .page_o (dec_page)
    );

    bcg_seq_ctrl #(.COL_W(COL_W)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .term_i   (term_i),
        .col_i    (col_i),
        .wrap_i   (wrap_i),
        .mask_i   (dec_mask),
        .page_i   (dec_page),
        .active_o (valid_o),
        .cnt_o    (cnt),
        .base_o   (base),
        .mask_o   (mask_q),
        .ilv_o    (ilv),
        .last_o   (last_o)
    );

    bcg_addr_map #(.COL_W(COL_W)) map_i (
        .base_i (base),
        .cnt_i  (cnt),
        .mask_i (mask_q),
        .ilv_i  (ilv),
        .col_o  (col_o)
    );

    // R6: last flag only on a valid beat
    a_r6_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    // R4: bits above the wrap group stay fixed between beats
    a_r4_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o) && !$past(start_i))
            |-> (((col_o ^ $past(col_o)) & ~mask_q) == '0));

    // R9: single-write write request is one beat long
    a_r9_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && wr_i && bsw_i) |=> last_o);
endmodule

// File: tb/burst_col_gen_tb_top.sv
`timescale 1ns/1ps
module burst_col_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [8:0] col_i = '0;
    logic [2:0] blen_i = '0;
    logic       wrap_i = 1'b0;
    logic       wr_i = 1'b0;
    logic       bsw_i = 1'b0;
    logic       term_i = 1'b0;
    logic [8:0] col_o;
    logic       valid_o;
    logic       last_o;

    int total = 0;
    int fails = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    burst_col_gen dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .col_i(col_i),
        .blen_i(blen_i), .wrap_i(wrap_i), .wr_i(wr_i), .bsw_i(bsw_i),
        .term_i(term_i), .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            total = total + 1;
            fails = fails + 1;
            $display("FAIL watchdog actual=%0d expected=<50000", cyc);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    // {col[9], code[3], wrap, wr, bsw, len[10]}
    localparam logic [24:0] VEC [11] = '{
        {9'd0,   3'd0, 1'b0, 1'b0, 1'b0, 10'd1},
        {9'd7,   3'd1, 1'b0, 1'b0, 1'b0, 10'd2},
        {9'd5,   3'd2, 1'b0, 1'b0, 1'b0, 10'd4},
        {9'd13,  3'd3, 1'b0, 1'b0, 1'b0, 10'd8},
        {9'd13,  3'd3, 1'b1, 1'b0, 1'b0, 10'd8},
        {9'd255, 3'd2, 1'b1, 1'b0, 1'b0, 10'd4},
        {9'd300, 3'd5, 1'b0, 1'b0, 1'b0, 10'd1},
        {9'd42,  3'd3, 1'b0, 1'b1, 1'b1, 10'd1},
        {9'd42,  3'd3, 1'b1, 1'b0, 1'b1, 10'd8},
        {9'd511, 3'd2, 1'b0, 1'b1, 1'b0, 10'd4},
        {9'd6,   3'd1, 1'b1, 1'b0, 1'b0, 10'd2}
    };

    task automatic check(input string req, input int act, input int exp_v);
        total = total + 1;
        if (act != exp_v) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // Reference address: bl=512 means full page.
    function automatic int exp_col(input int base, input int bl, input bit ilv, input int k);
        int low;
        int grp;
        if (bl == 512) return (base + k) % 512;
        low = base % bl;
        grp = base - low;
        if (ilv) return grp + (low ^ (k % bl));
        return grp + ((low + k) % bl);
    endfunction

    task automatic issue(input int col, input int code, input bit wrap, input bit wr, input bit bsw);
        start_i = 1'b1;
        col_i = 9'(col);
        blen_i = 3'(code);
        wrap_i = wrap;
        wr_i = wr;
        bsw_i = bsw;
    endtask

    task automatic run_burst(input int col, input int code, input bit wrap,
                             input bit wr, input bit bsw, input int len);
        string tag;
        tag = (wr && bsw) ? "R9" : (wrap ? "R5" : "R4");
        @(negedge clk);
        issue(col, code, wrap, wr, bsw);
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < len; k++) begin
            // R10: scramble request inputs while the burst runs
            col_i = ~col_i;
            blen_i = 3'd7;
            wrap_i = ~wrap_i;
            wr_i = ~wr_i;
            check("R3 valid during burst", int'(valid_o), 1);
            check({tag, " R10 column"}, int'(col_o), exp_col(col, len, wrap, k));
            check("R6 last flag", int'(last_o), (k == len - 1) ? 1 : 0);
            @(negedge clk);
        end
        check("R3 valid after burst", int'(valid_o), 0);
    endtask

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        check("R1 valid in reset", int'(valid_o), 0);
        check("R1 last in reset", int'(last_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", int'(valid_o), 0);
        check("R1 last after reset", int'(last_o), 0);

        for (int v = 0; v < 11; v++) begin
            run_burst(int'(VEC[v][24:16]), int'(VEC[v][15:13]), VEC[v][12],
                      VEC[v][11], VEC[v][10], int'(VEC[v][9:0]));
        end

        // R8: terminate mid burst
        @(negedge clk);
        issue(20, 3, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        start_i = 1'b0;
        check("R8 beat0", int'(col_o), 20);
        @(negedge clk);
        @(negedge clk);
        check("R8 beat2", int'(col_o), 22);
        term_i = 1'b1;
        @(negedge clk);
        term_i = 1'b0;
        check("R8 valid after term", int'(valid_o), 0);
        check("R8 last after term", int'(last_o), 0);

        // R8: terminate while idle has no effect on a following burst
        term_i = 1'b1;
        repeat (2) @(negedge clk);
        check("R8 idle term valid", int'(valid_o), 0);
        term_i = 1'b0;
        run_burst(70, 1, 1'b0, 1'b0, 1'b0, 2);

        // R2: new start during a burst replaces it
        @(negedge clk);
        issue(100, 3, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        check("R2 old beat1", int'(col_o), 101);
        issue(200, 1, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        start_i = 1'b0;
        check("R2 restart valid", int'(valid_o), 1);
        check("R2 restart beat0", int'(col_o), 200);
        check("R2 restart not last", int'(last_o), 0);
        @(negedge clk);
        check("R2 restart beat1", int'(col_o), 201);
        check("R2 restart last", int'(last_o), 1);
        @(negedge clk);
        check("R2 restart done", int'(valid_o), 0);

        // R8: start and terminate together, start wins
        issue(33, 2, 1'b0, 1'b0, 1'b0);
        term_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        term_i = 1'b0;
        check("R8 start wins valid", int'(valid_o), 1);
        check("R8 start wins col", int'(col_o), 33);
        @(negedge clk);
        check("R8 start wins beat1", int'(col_o), 34);
        term_i = 1'b1;
        @(negedge clk);
        term_i = 1'b0;

        // R7: full page crossing 511, interleave request ignored
        issue(508, 7, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 520; k++) begin
            check("R7 page valid", int'(valid_o), 1);
            check("R7 page col", int'(col_o), (508 + k) % 512);
            check("R7 page no last", int'(last_o), 0);
            @(negedge clk);
        end
        term_i = 1'b1;
        @(negedge clk);
        term_i = 1'b0;
        check("R7 page terminated", int'(valid_o), 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule